// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block sits on the host side of a pseudo-SRAM and owns the two chip-enable lines during the phases in which the bus master may not touch the memory. It covers the settle time after the supply comes up, entry into the low-power state, and the return from it. It drives the active-high enable directly. It also provides an override that holds the active-low enable inactive (high), and a ready flag that tells the bus master when ordinary accesses are allowed.

Every wait is a parameter counted in clock cycles. The hold after the active-high enable rises depends on the retention setting that was in force when sleep was requested. If the array kept no data, the full power-up hold applies, so waking from a non-retaining sleep works the same as a reset. If part of the array was retained, a short hold is enough. Losing the supply at any point restarts the whole power-up sequence.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, and at once when it is asserted, `ce2` is 0, `ce1_force_hi` is 1 and `ready` is 0.
- R2: In the power-up phase, `ce2` stays 0 until `supply_good` has been sampled high on T_PU_LOW consecutive clock edges. A single low sample restarts the count.
- R3: After `ce2` rises at power-up, `ready` stays 0 and `ce1_force_hi` stays 1 for exactly T_HOLD_LONG cycles. Then `ready` is 1 and `ce1_force_hi` is 0.
- R4: When `sleep_req` is sampled high while `ready` is 1, the next cycle has `ready`=0 and `ce1_force_hi`=1 while `ce2` stays 1. `ce2` then falls after exactly T_CE1_SETUP cycles.
- R5: `ce2` stays low for max(T_PD_MIN, d) cycles, where d is the position (counted from 1) of the first low cycle in which `wake_req` is high. A wake that comes earlier than T_PD_MIN is remembered.
- R6: `wake_req` has no effect unless the block is on its way into or inside the low-power state. `sleep_req` has no effect unless `ready` is 1.
- R7: After `ce2` rises on wake, the hold with `ready`=0 lasts T_HOLD_SHORT cycles if `ret_mode` was 2'b01 or 2'b10 in the cycle sleep was accepted. For 2'b00 or 2'b11 (no retention) it lasts T_HOLD_LONG. Later changes to `ret_mode` are ignored.
- R8: `supply_good` sampled low in any state gives `ce2`=0, `ready`=0 and `ce1_force_hi`=1 on the next cycle. The full power-up sequence (R2, R3) then restarts, whatever the retention setting.
- R9: `ce2` rises only while `ce1_force_hi` is 1. Except on supply loss, `ce2` falls only after `ce1_force_hi` was already 1 in the previous cycle.
- R10: Whenever `ready` is 1, `ce2` is 1 and `ce1_force_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Memory supply has reached its minimum level |
| sleep_req | input | 1 | Request to put the memory into its low-power state |
| wake_req | input | 1 | Request to leave the low-power state |
| ret_mode | input | 2 | Currently programmed retention setting (01/10 retain part of the array, 00/11 retain nothing) |
| ce2 | output | 1 | Level for the active-high chip enable |
| ce1_force_hi | output | 1 | Forces the active-low chip enable to its inactive level |
| ready | output | 1 | Memory may be accessed by the bus master |

## Verification
The checker assumes `supply_good`, `sleep_req` and `wake_req` are already synchronous to `clk`. It also assumes that every timer parameter is at least 1, so each phase lasts at least one cycle. The stimulus changes inputs only on falling clock edges and uses small timer values. It raises `wake_req` only from the ready state or from within the low-power state, and it drops `supply_good` only at chosen points: during power-up, inside the low-power state and in the ready state.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [2:0] {
    S_POWER_UP_WAIT = 3'd0,
    S_CE2_RISE_HOLD = 3'd1,
    S_READY         = 3'd2,
    S_ENTER_PD      = 3'd3,
    S_PD            = 3'd4,
    S_EXIT_HOLD     = 3'd5
  } seq_state_t;

  localparam logic [1:0] RET_NONE_A = 2'b00;
  localparam logic [1:0] RET_PART_S = 2'b01;
  localparam logic [1:0] RET_PART_L = 2'b10;
  localparam logic [1:0] RET_NONE_B = 2'b11;

  // Only the two partial settings keep data across the low-power state.
  function automatic logic keeps_data(input logic [1:0] m);
    return (m == RET_PART_S) || (m == RET_PART_L);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_timer.sv
module psram_seq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic          done
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  // done marks the last cycle of a phase that lasts 'limit' cycles.
  assign done   = (cnt_q == (limit - TW'(1)));
  assign cnt_en = clr | ~done;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!done) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/psram_seq_retain.sv
module psram_seq_retain
  import psram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [1:0] ret_mode,
  input  logic       arm,
  input  logic       wake_req,
  output logic       wake_seen,
  output logic       keep_q
);

  logic       pend_q;
  logic       pend_d;
  logic [1:0] mode_q;

  // A wake is remembered only while heading into or sitting in the low-power state.
  always_comb begin
    pend_d = 1'b0;
    if (arm) begin
      pend_d = pend_q | wake_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RET_NONE_A;
    end else if (capture) begin
      mode_q <= ret_mode;
    end
  end

  assign wake_seen = pend_q | wake_req;
  assign keep_q    = keeps_data(mode_q);

endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
  import psram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_good,
  input  logic       sleep_req,
  input  logic       wake_seen,
  input  logic       tmr_done,
  output seq_state_t state_q,
  output logic       tmr_clr,
  output logic       sleep_take,
  output logic       pd_arm,
  output logic       ce2_q,
  output logic       force_q,
  output logic       ready_q
);

  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_good) begin
      state_d = S_POWER_UP_WAIT;
    end else begin
      unique case (state_q)
        S_POWER_UP_WAIT: if (tmr_done)              state_d = S_CE2_RISE_HOLD;
        S_CE2_RISE_HOLD: if (tmr_done)              state_d = S_READY;
        S_READY:         if (sleep_req)             state_d = S_ENTER_PD;
        S_ENTER_PD:      if (tmr_done)              state_d = S_PD;
        S_PD:            if (tmr_done && wake_seen) state_d = S_EXIT_HOLD;
        S_EXIT_HOLD:     if (tmr_done)              state_d = S_READY;
        default:                                    state_d = S_POWER_UP_WAIT;
      endcase
    end
  end

  assign tmr_clr    = (state_d != state_q) ||
                      ((state_q == S_POWER_UP_WAIT) && !supply_good);
  assign sleep_take = (state_q == S_READY) && (state_d == S_ENTER_PD);
  assign pd_arm     = (state_q == S_ENTER_PD) || (state_q == S_PD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_POWER_UP_WAIT;
    end else begin
      state_q <= state_d;
    end
  end

  // Pin levels are flopped from the next state so they switch cleanly with the state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce2_q   <= 1'b0;
      force_q <= 1'b1;
      ready_q <= 1'b0;
    end else begin
      ce2_q   <= (state_d == S_CE2_RISE_HOLD) || (state_d == S_READY) ||
                 (state_d == S_ENTER_PD)      || (state_d == S_EXIT_HOLD);
      force_q <= (state_d != S_READY);
      ready_q <= (state_d == S_READY);
    end
  end

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_seq_pkg::*;
#(
  parameter int unsigned T_PU_LOW     = 12500,
  parameter int unsigned T_HOLD_LONG  = 75000,
  parameter int unsigned T_HOLD_SHORT = 250,
  parameter int unsigned T_CE1_SETUP  = 3,
  parameter int unsigned T_PD_MIN     = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_good,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic [1:0] ret_mode,
  output logic       ce2,
  output logic       ce1_force_hi,
  output logic       ready
);

  localparam int unsigned MAX_T = max_u(max_u(T_PU_LOW, T_HOLD_LONG),
                                        max_u(max_u(T_HOLD_SHORT, T_CE1_SETUP), T_PD_MIN));
  localparam int unsigned TW    = $clog2(MAX_T + 1);

  logic          rst_meta_q;
  logic          rst_sync_q;
  seq_state_t    state_q;
  logic          tmr_clr;
  logic          tmr_done;
  logic [TW-1:0] tmr_limit;
  logic          sleep_take;
  logic          pd_arm;
  logic          wake_seen;
  logic          keep_q;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    unique case (state_q)
      S_POWER_UP_WAIT: tmr_limit = TW'(T_PU_LOW);
      S_CE2_RISE_HOLD: tmr_limit = TW'(T_HOLD_LONG);
      S_ENTER_PD:      tmr_limit = TW'(T_CE1_SETUP);
      S_PD:            tmr_limit = TW'(T_PD_MIN);
      S_EXIT_HOLD:     tmr_limit = keep_q ? TW'(T_HOLD_SHORT) : TW'(T_HOLD_LONG);
      default:         tmr_limit = TW'(1);
    endcase
  end

  psram_seq_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  psram_seq_retain u_retain (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .capture   (sleep_take),
    .ret_mode  (ret_mode),
    .arm       (pd_arm),
    .wake_req  (wake_req),
    .wake_seen (wake_seen),
    .keep_q    (keep_q)
  );

  psram_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .supply_good (supply_good),
    .sleep_req   (sleep_req),
    .wake_seen   (wake_seen),
    .tmr_done    (tmr_done),
    .state_q     (state_q),
    .tmr_clr     (tmr_clr),
    .sleep_take  (sleep_take),
    .pd_arm      (pd_arm),
    .ce2_q       (ce2),
    .force_q     (ce1_force_hi),
    .ready_q     (ready)
  );

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int unsigned T_PU_LOW     = 12500,
  parameter int unsigned T_HOLD_SHORT = 250,
  parameter int unsigned T_PD_MIN     = 17
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_good,
  input logic       sleep_req,
  input logic       wake_req,
  input logic [1:0] ret_mode,
  input logic       ce2,
  input logic       ce1_force_hi,
  input logic       ready
);

  localparam int unsigned MIN_LOW = (T_PD_MIN < T_PU_LOW) ? T_PD_MIN : T_PU_LOW;
  localparam int unsigned CW      = $clog2(((MIN_LOW > T_HOLD_SHORT) ? MIN_LOW : T_HOLD_SHORT) + 2);

  logic [CW-1:0] low_run_q;
  logic [CW-1:0] hold_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      hold_run_q <= '0;
    end else begin
      if (ce2) low_run_q <= '0;
      else if (low_run_q != '1) low_run_q <= low_run_q + CW'(1);
      if (!ce2 || ready) hold_run_q <= '0;
      else if (hold_run_q != '1) hold_run_q <= hold_run_q + CW'(1);
    end
  end

  a_r10_ready_levels: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce2 && !ce1_force_hi));

  a_r4_sleep_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sleep_req && supply_good) |=> (!ready && ce2 && ce1_force_hi));

  a_r6_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sleep_req && supply_good) |=> ready);

  a_r8_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |=> (!ce2 && !ready && ce1_force_hi));

  a_r9_rise_forced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (ce1_force_hi && !ready));

  a_r9_fall_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce2) && $past(supply_good)) |-> $past(ce1_force_hi));

  a_r5_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (low_run_q >= CW'(MIN_LOW)));

  a_r7_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hold_run_q >= CW'(T_HOLD_SHORT)));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .T_PU_LOW     (T_PU_LOW),
  .T_HOLD_SHORT (T_HOLD_SHORT),
  .T_PD_MIN     (T_PD_MIN)
) u_chk (.*);

// File: tb/tb_psram_pwr_seq.sv
module tb_psram_pwr_seq;

  localparam int PU    = 20;
  localparam int LONG  = 40;
  localparam int SHORT = 6;
  localparam int SETUP = 3;
  localparam int PDMIN = 10;

  localparam int NV = 6;
  localparam int V_MODE [NV] = '{0, 1, 2, 3, 1, 0};
  localparam int V_WAKE [NV] = '{2, 3, 15, 10, 1, 12};
  localparam int V_LATE [NV] = '{0, 1, 2, 3, 0, 2};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_good;
  logic       sleep_req;
  logic       wake_req;
  logic [1:0] ret_mode;
  logic       ce2;
  logic       ce1_force_hi;
  logic       ready;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  psram_pwr_seq #(
    .T_PU_LOW(PU), .T_HOLD_LONG(LONG), .T_HOLD_SHORT(SHORT),
    .T_CE1_SETUP(SETUP), .T_PD_MIN(PDMIN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .sleep_req(sleep_req),
    .wake_req(wake_req), .ret_mode(ret_mode), .ce2(ce2),
    .ce1_force_hi(ce1_force_hi), .ready(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hold(input int m);
    return (m == 1 || m == 2) ? SHORT : LONG;
  endfunction

  // Counts falling edges, starting with the current one, while the condition holds.
  task automatic run_while(input int sel, output int n);
    n = 0;
    while (n < 1000 && ((sel == 0 && !ce2) || (sel == 1 && ce2) || (sel == 2 && !ready))) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sleep_cycle(input int m, input int d, input int late, input bit sleep_in_hold,
                             output int n_setup, output int n_low, output int n_hold);
    sleep_req = 1'b1;
    ret_mode  = 2'(m);
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R4 ready drop", int'(ready), 0);
    chk("R4 ce1 forced", int'(ce1_force_hi), 1);
    run_while(1, n_setup);
    n_low = 0;
    while (!ce2 && n_low < 300) begin
      n_low++;
      wake_req = (n_low == d);
      if (n_low == 2) ret_mode = 2'(late);
      @(negedge clk);
    end
    wake_req = 1'b0;
    n_hold = 0;
    while (!ready && n_hold < 300) begin
      n_hold++;
      sleep_req = sleep_in_hold && (n_hold <= 2);
      @(negedge clk);
    end
    sleep_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, ns, nl, nh;
    rst_n = 1'b0; supply_good = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; ret_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 reset ce2", int'(ce2), 0);
    chk("R1 reset force", int'(ce1_force_hi), 1);
    chk("R1 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 no supply ce2", int'(ce2), 0);

    // R2: a low sample restarts the supply count
    supply_good = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 partial count", int'(ce2), 0);
    supply_good = 1'b0;
    @(negedge clk);
    supply_good = 1'b1;
    run_while(0, n);
    chk("R2 low after supply", n, PU);
    chk("R9 forced at rise", int'(ce1_force_hi), 1);
    run_while(2, n);
    chk("R3 power-up hold", n, LONG);
    chk("R3 force released", int'(ce1_force_hi), 0);
    chk("R10 ce2 in ready", int'(ce2), 1);

    // R6: wake in ready does nothing
    wake_req = 1'b1;
    repeat (3) @(negedge clk);
    wake_req = 1'b0;
    chk("R6 wake ignored ready", int'(ready), 1);
    chk("R6 wake ignored ce2", int'(ce2), 1);

    for (int i = 0; i < NV; i++) begin
      sleep_cycle(V_MODE[i], V_WAKE[i], V_LATE[i], 1'b0, ns, nl, nh);
      chk("R4 setup cycles", ns, SETUP);
      chk("R5 low cycles", nl, (V_WAKE[i] > PDMIN) ? V_WAKE[i] : PDMIN);
      chk("R7 exit hold", nh, exp_hold(V_MODE[i]));
      chk("R10 ready force", int'(ce1_force_hi), 0);
    end

    // R6: sleep during exit hold is ignored
    sleep_cycle(2, 4, 2, 1'b1, ns, nl, nh);
    chk("R6 hold unaffected", nh, SHORT);
    repeat (4) @(negedge clk);
    chk("R6 stays ready", int'(ready), 1);

    // R8: supply loss inside the low-power state restarts power-up with long hold
    sleep_req = 1'b1; ret_mode = 2'b01;
    @(negedge clk);
    sleep_req = 1'b0;
    run_while(1, n);
    repeat (2) @(negedge clk);
    supply_good = 1'b0;
    @(negedge clk);
    chk("R8 pd loss ce2", int'(ce2), 0);
    chk("R8 pd loss force", int'(ce1_force_hi), 1);
    supply_good = 1'b1;
    run_while(0, n);
    chk("R8 restart low", n, PU);
    run_while(2, n);
    chk("R8 restart hold", n, LONG);

    // R8: supply loss in ready
    supply_good = 1'b0;
    @(negedge clk);
    chk("R8 ready loss ready", int'(ready), 0);
    chk("R8 ready loss ce2", int'(ce2), 0);
    supply_good = 1'b1;
    run_while(0, n);
    chk("R8 ready loss relow", n, PU);
    run_while(2, n);
    chk("R8 ready loss hold", n, LONG);

    // R1: asynchronous reset takes effect at once
    rst_n = 1'b0;
    #1;
    chk("R1 async ce2", int'(ce2), 0);
    chk("R1 async force", int'(ce1_force_hi), 1);
    chk("R1 async ready", int'(ready), 0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule